// File: doc/BRIEF.md
# JTAG Register Access Scan Chain

This block is a data-register scan chain that sits behind a TAP controller and lets a debug host reach a small bank of 32-bit registers. Every scan moves one 40-bit frame through the chain. The frame carries a data word, a register address and a direction flag. When the TAP passes through Update-DR, the block either writes the data word to the addressed register or starts a read of it. A read result is not returned in the same scan. It is loaded into the data field at the next Capture-DR, so the host collects it during the following scan.

The register bank lives outside the block. The block sends it an address, a one-cycle write strobe with write data, or a one-cycle read strobe, and it samples the read data in the strobe cycle. Some registers have a side effect when they are read. The RAM-data register at address 4 returns one trace word per strobe and advances its read pointer. A host therefore streams trace memory by repeating reads of address 4. On the last scan it puts the side-effect-free identification register at address 0 in the address field, so that no extra word is consumed.

The chain responds only while the access instruction is loaded and internal scan chain 0 is selected. When it is not selected, it ignores the TAP strobes and holds TDO low.

Top module: `jtag_regacc_chain`

## Requirements
- R1: A frame is 40 bits and is shifted least significant bit first, from tdi towards tdo. Bits 0 to 31 hold the data, bits 32 to 38 hold the register address, and bit 39 holds the direction flag.
- R2: If the flag is 1 (write) and the address is below NUM_REGS, reg_wr is high for exactly the one cycle after Update-DR. In that cycle reg_addr and reg_wdata carry the frame's address and data.
- R3: If the flag is 0 (read) and the address is below NUM_REGS, reg_rd is high for exactly the one cycle after Update-DR. The block samples reg_rdata in that cycle, and the sampled value appears in the data field of the next scan.
- R4: Capture-DR loads the address and flag fields with zeros. The data field keeps the most recent read result, and a write scan does not change that result.
- R5: An address at or above NUM_REGS produces no strobe. A write to it has no effect, and a read of it returns zero on the next scan.
- R6: Each read scan gives exactly one read strobe. Consecutive reads of address 4 therefore return successive trace words, and a closing read of address 0 consumes none.
- R7: Unless ir_value equals the access instruction 0xC and chain_num equals 0, tdo stays 0 and Update-DR produces no strobe.
- R8: After reset both strobes are low and the first captured data field is zero.
- R9: reg_wr and reg_rd are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_value | input | IR_W | Instruction currently loaded in the TAP |
| chain_num | input | CHAIN_W | Selected internal scan chain number |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out; low when the chain is not selected |
| reg_addr | output | 7 | Register address for the current access |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data from the register bank, sampled in the reg_rd cycle |

## Verification
The bench builds the chain with its default parameters: access instruction 0xC, chain 0, and eight implemented addresses. With only eight addresses, unimplemented addresses such as 9 are easy to reach, and they show that the block suppresses strobes and returns zero for them. The bench attaches a behavioural register bank that includes a trace RAM with a writable read pointer. This lets the one-scan-late read pipeline and the RAM streaming side effect be seen at the pins. Scans with the wrong instruction and with the wrong chain confirm that the chain ignores them.

// File: rtl/jtag_regacc_pkg.sv
package jtag_regacc_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int FRAME_W = DATA_W + ADDR_W + 1;

    // Bit 0 of the packed struct is the first bit shifted (data LSB).
    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        ACC_IGNORE,
        ACC_READ,
        ACC_READ_ZERO,
        ACC_WRITE
    } acc_kind_e;

    function automatic logic addr_present(input logic [ADDR_W-1:0] a,
                                          input int unsigned nregs);
        return 32'(a) < nregs;
    endfunction

    function automatic acc_kind_e decode_access(input frame_t f,
                                                input int unsigned nregs);
        if (f.write)
            return addr_present(f.addr, nregs) ? ACC_WRITE : ACC_IGNORE;
        return addr_present(f.addr, nregs) ? ACC_READ : ACC_READ_ZERO;
    endfunction

    function automatic frame_t capture_frame(input logic [DATA_W-1:0] d);
        frame_t f;
        f.write = 1'b0;
        f.addr  = '0;
        f.data  = d;
        return f;
    endfunction

endpackage

// File: rtl/regacc_shift_reg.sv
module regacc_shift_reg
    import jtag_regacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_capture,
    input  logic              en_shift,
    input  logic              tdi,
    input  logic [DATA_W-1:0] cap_data,
    output frame_t            frame_o,
    output logic              tdo_o
);

    frame_t sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (en_capture) begin
            sr_q <= capture_frame(cap_data);
        end else if (en_shift) begin
            sr_q <= frame_t'({tdi, sr_q[FRAME_W-1:1]});
        end
    end

    assign frame_o = sr_q;
    assign tdo_o   = en_shift ? sr_q[0] : 1'b0;

endmodule

// File: rtl/regacc_access_ctl.sv
module regacc_access_ctl
    import jtag_regacc_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  frame_t            req,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [DATA_W-1:0] rd_result
);

    acc_kind_e kind;
    logic      pend_q;
    logic      pend_live_q;

    assign kind = decode_access(req, NUM_REGS);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_addr    <= '0;
            reg_wdata   <= '0;
            reg_wr      <= 1'b0;
            reg_rd      <= 1'b0;
            rd_result   <= '0;
            pend_q      <= 1'b0;
            pend_live_q <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            pend_q <= 1'b0;
            if (fire) begin
                reg_addr <= req.addr;
                unique case (kind)
                    ACC_WRITE: begin
                        reg_wr    <= 1'b1;
                        reg_wdata <= req.data;
                    end
                    ACC_READ: begin
                        reg_rd      <= 1'b1;
                        pend_q      <= 1'b1;
                        pend_live_q <= 1'b1;
                    end
                    ACC_READ_ZERO: begin
                        pend_q      <= 1'b1;
                        pend_live_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (pend_q) begin
                rd_result <= pend_live_q ? reg_rdata : '0;
            end
        end
    end

endmodule

// File: rtl/jtag_regacc_chain.sv
module jtag_regacc_chain
    import jtag_regacc_pkg::*;
#(
    parameter int                IR_W         = 4,
    parameter logic [IR_W-1:0]   ACCESS_IR    = 4'hC,
    parameter int                CHAIN_W      = 4,
    parameter logic [CHAIN_W-1:0] ACCESS_CHAIN = '0,
    parameter int unsigned       NUM_REGS     = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IR_W-1:0]    ir_value,
    input  logic [CHAIN_W-1:0] chain_num,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    output logic               tdo,
    output logic [6:0]         reg_addr,
    output logic               reg_wr,
    output logic               reg_rd,
    output logic [31:0]        reg_wdata,
    input  logic [31:0]        reg_rdata
);

    logic              chain_sel;
    frame_t            shift_frame;
    logic [DATA_W-1:0] rd_result;

    assign chain_sel = (ir_value == ACCESS_IR) && (chain_num == ACCESS_CHAIN);

    regacc_shift_reg u_shift (
        .clk        (clk),
        .rst        (rst),
        .en_capture (chain_sel && capture_dr),
        .en_shift   (chain_sel && shift_dr),
        .tdi        (tdi),
        .cap_data   (rd_result),
        .frame_o    (shift_frame),
        .tdo_o      (tdo)
    );

    regacc_access_ctl #(.NUM_REGS(NUM_REGS)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .fire      (chain_sel && update_dr),
        .req       (shift_frame),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .rd_result (rd_result)
    );

endmodule

// File: rtl/jtag_regacc_chk.sv
module jtag_regacc_chk
    import jtag_regacc_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        sel,
    input logic        capture_dr,
    input logic        update_dr,
    input frame_t      frame,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [6:0]  reg_addr
);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    // R2
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    // R2
    wr_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && update_dr && frame.write && (32'(frame.addr) < NUM_REGS))
        |=> (reg_wr && reg_addr == $past(frame.addr)));

    // R3
    rd_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && update_dr && !frame.write && (32'(frame.addr) < NUM_REGS))
        |=> (reg_rd && !reg_wr));

    // R5
    unimpl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && update_dr && (32'(frame.addr) >= NUM_REGS))
        |=> (!reg_wr && !reg_rd));

    // R7
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (update_dr && !sel) |=> (!reg_wr && !reg_rd));

    // R4
    capture_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && capture_dr) |=> (!frame.write && frame.addr == '0));

endmodule

bind jtag_regacc_chain jtag_regacc_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .sel        (chain_sel),
    .capture_dr (capture_dr),
    .update_dr  (update_dr),
    .frame      (shift_frame),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr)
);

// File: tb/jtag_regacc_chain_tb.sv
module jtag_regacc_chain_tb_top;

    localparam int CLK_P  = 10;
    localparam int NREGS  = 8;
    localparam logic [31:0] ID_VAL = 32'h1B00_7E11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ir_value = 4'hC;
    logic [3:0]  chain_num = 4'h0;
    logic        capture_dr = 1'b0;
    logic        shift_dr = 1'b0;
    logic        update_dr = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;
    logic [6:0]  reg_addr;
    logic        reg_wr;
    logic        reg_rd;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    jtag_regacc_chain dut_i (
        .clk(clk), .rst(rst), .ir_value(ir_value), .chain_num(chain_num),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] ram_word(input int i);
        return 32'hA500_0000 + 32'(i * 3);
    endfunction

    // Behavioural register bank: 0 = ID, 4 = RAM data, 5 = RAM read pointer.
    logic [31:0] bank [NREGS];
    logic [3:0]  bank_ptr;
    int rd_strobes  = 0;
    int bad_strobes = 0;
    int overlaps    = 0;

    always_comb begin
        if (reg_addr >= 7'(NREGS))  reg_rdata = 32'hBAD0_0000 | 32'(reg_addr);
        else if (reg_addr == 7'd0)  reg_rdata = ID_VAL;
        else if (reg_addr == 7'd4)  reg_rdata = ram_word(int'(bank_ptr));
        else if (reg_addr == 7'd5)  reg_rdata = 32'(bank_ptr);
        else                        reg_rdata = bank[reg_addr[2:0]];
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) bank[i] <= '0;
            bank_ptr <= '0;
        end else begin
            if (reg_wr && reg_addr == 7'd5) bank_ptr <= reg_wdata[3:0];
            else if (reg_wr && reg_addr < 7'(NREGS)) bank[reg_addr[2:0]] <= reg_wdata;
            if (reg_rd && reg_addr == 7'd4) bank_ptr <= bank_ptr + 4'd1;
            if (reg_rd) rd_strobes++;
            if ((reg_wr || reg_rd) && reg_addr >= 7'(NREGS)) bad_strobes++;
            if (reg_wr && reg_rd) overlaps++;
        end
    end

    // Reference model state
    logic [31:0] m_regs [NREGS];
    int          m_ptr   = 0;
    logic [31:0] m_res   = '0;
    int          m_reads = 0;

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scan(input string req, input bit wr, input logic [6:0] a,
                        input logic [31:0] d, input bit sel);
        logic [39:0] frame_in;
        logic [39:0] got;
        logic [39:0] exp;
        frame_in = {wr, a, d};
        exp = sel ? {8'h00, m_res} : 40'h0;
        @(negedge clk); capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tdi = frame_in[i];
            #1 got[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge clk); update_dr = 1'b0;
        repeat (2) @(negedge clk);
        check(req, got, exp);
        if (sel) begin
            if (wr) begin
                if (a < 7'(NREGS)) begin
                    if (a == 7'd5) m_ptr = int'(d[3:0]);
                    else if (a != 7'd0 && a != 7'd4) m_regs[a[2:0]] = d;
                end
            end else if (a >= 7'(NREGS)) begin
                m_res = '0;
            end else begin
                m_reads++;
                if (a == 7'd0)      m_res = ID_VAL;
                else if (a == 7'd4) begin m_res = ram_word(m_ptr); m_ptr = (m_ptr + 1) % 16; end
                else if (a == 7'd5) m_res = 32'(m_ptr);
                else                m_res = m_regs[a[2:0]];
            end
        end
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) m_regs[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check("R8 strobes", {38'h0, reg_wr, reg_rd}, 40'h0);
        check("R8 tdo", {39'h0, tdo}, 40'h0);
        scan("R8 R4 first capture", 1'b0, 7'd0, 32'h0, 1'b1);
        // R2 R3 R4: write then read back one scan late
        scan("R3 ID return", 1'b1, 7'd2, 32'hCAFE_1234, 1'b1);
        scan("R4 write keeps result", 1'b0, 7'd2, 32'hFFFF_FFFF, 1'b1);
        scan("R2 written value", 1'b0, 7'd0, 32'h0, 1'b1);
        // R1: bit order with edge patterns
        scan("R1 ID", 1'b1, 7'd1, 32'h8000_0001, 1'b1);
        scan("R1 write", 1'b1, 7'd7, 32'h0F0F_F0F0, 1'b1);
        scan("R1 read a1", 1'b0, 7'd1, 32'h0, 1'b1);
        scan("R1 read a7", 1'b0, 7'd7, 32'h0, 1'b1);
        scan("R1 data order", 1'b0, 7'd0, 32'h0, 1'b1);
        // R6: RAM streaming
        scan("R6 set ptr", 1'b1, 7'd5, 32'h3, 1'b1);
        scan("R6 ram0", 1'b0, 7'd4, 32'h0, 1'b1);
        scan("R6 ram1", 1'b0, 7'd4, 32'h0, 1'b1);
        scan("R6 ram2", 1'b0, 7'd4, 32'h0, 1'b1);
        scan("R6 ram3 close", 1'b0, 7'd0, 32'h0, 1'b1);
        scan("R6 no extra word", 1'b0, 7'd5, 32'h0, 1'b1);
        scan("R6 ptr value", 1'b0, 7'd0, 32'h0, 1'b1);
        // R5: unimplemented address
        scan("R5 write unimpl", 1'b1, 7'd9, 32'h1111_2222, 1'b1);
        scan("R5 read unimpl", 1'b0, 7'd9, 32'h0, 1'b1);
        scan("R5 zero returned", 1'b0, 7'd0, 32'h0, 1'b1);
        check("R5 no strobes at unimpl", 40'(bad_strobes), 40'h0);
        // R7: deselected by instruction and by chain
        ir_value = 4'h2;
        scan("R7 wrong instr", 1'b1, 7'd2, 32'h5555_AAAA, 1'b0);
        ir_value = 4'hC; chain_num = 4'h1;
        scan("R7 wrong chain", 1'b1, 7'd2, 32'h5555_AAAA, 1'b0);
        chain_num = 4'h0;
        scan("R7 after deselect", 1'b0, 7'd2, 32'h0, 1'b1);
        scan("R7 reg unchanged", 1'b0, 7'd0, 32'h0, 1'b1);
        check("R6 one strobe per read", 40'(rd_strobes), 40'(m_reads));
        check("R9 no overlap", 40'(overlaps), 40'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule